// File: doc/BRIEF.md
# Four-Mode 16-Bit Barrel Shifter

This block moves a 16-bit operand by 0 to 15 bit positions in one of four modes: left rotate, left shift with zero fill, right rotate and arithmetic right shift. It is purely combinational. There is no clock, no reset and no storage, so the result follows the inputs within the same evaluation. It is intended to sit inside an ALU datapath, where a 2-bit mode field and the low four bits of a second operand steer it.

The operand passes through four cascaded stages that move it by 1, 2, 4 and 8 positions. Each stage is enabled by one bit of the amount. A small decoder turns the mode code into three controls that every stage shares: the direction, whether the bits that leave one end come back in at the other, and the bit that fills vacated positions. The fill bit is 0 for the left shift and the operand's top bit for the arithmetic right shift.

The block has no states and no transitions. Its only "state" is the mode that the decoder selects from the mode code.

Top module: `quad_mode_shifter`

## Requirements
- R1: For every amount from 0 to 15, the result equals the operand moved by exactly that many bit positions in the selected mode.
- R2: Mode code 2'b00 rotates left: result bit i equals operand bit (i - amount) mod 16.
- R3: Mode code 2'b01 shifts left. Result bit i equals operand bit (i - amount) for i >= amount. The lowest `amount` result bits are 0.
- R4: Mode code 2'b10 rotates right: result bit i equals operand bit (i + amount) mod 16.
- R5: Mode code 2'b11 shifts right arithmetically. Result bit i equals operand bit (i + amount) when i + amount < 16. Every higher result bit equals operand bit 15.
- R6: An amount of 0 returns the operand unchanged in all four modes.
- R7: The result follows a change on any input with no clock edge.
- R8: In both rotate modes the result holds the same number of 1 bits as the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Operand to be moved |
| amount_i | input | 4 | Unsigned shift or rotate distance, 0 to 15 |
| mode_i | input | 2 | Mode code: 00 rotate left, 01 shift left, 10 rotate right, 11 arithmetic right shift |
| result_o | output | 16 | Moved operand |

## Verification
The assertions are immediate checks that run whenever the combinational logic settles. They take for granted that every input holds a known 0 or 1 value. They also take for granted that the amount never exceeds 15, which the 4-bit width already ensures, and that all four mode codes are legal. The stimulus only ever drives fully defined values. It then waits a short delay after each change before comparing, so every check and every assertion sees settled logic and never an intermediate value.

// File: rtl/qms_pkg.sv
package qms_pkg;

    typedef enum logic [1:0] {
        MODE_ROT_LEFT  = 2'b00,
        MODE_SHIFT_LEFT = 2'b01,
        MODE_ROT_RIGHT = 2'b10,
        MODE_ARITH_RIGHT = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic go_left;
        logic wrap;
        logic fill;
    } stage_ctrl_t;

endpackage

// File: rtl/qms_mode_decode.sv
module qms_mode_decode
    import qms_pkg::*;
(
    input  shift_mode_e mode_i,
    input  logic        sign_i,
    output stage_ctrl_t ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (mode_i)
            MODE_ROT_LEFT: begin
                ctrl_o.go_left = 1'b1;
                ctrl_o.wrap    = 1'b1;
                ctrl_o.fill    = 1'b0;
            end
            MODE_SHIFT_LEFT: begin
                ctrl_o.go_left = 1'b1;
                ctrl_o.wrap    = 1'b0;
                ctrl_o.fill    = 1'b0;
            end
            MODE_ROT_RIGHT: begin
                ctrl_o.go_left = 1'b0;
                ctrl_o.wrap    = 1'b1;
                ctrl_o.fill    = 1'b0;
            end
            MODE_ARITH_RIGHT: begin
                ctrl_o.go_left = 1'b0;
                ctrl_o.wrap    = 1'b0;
                ctrl_o.fill    = sign_i;
            end
            default: ctrl_o = '0;
        endcase
    end

    // R5: the fill bit is zero in every mode except the arithmetic right shift
    always_comb begin
        if (mode_i != MODE_ARITH_RIGHT)
            assert_fill_zero_R5: assert (ctrl_o.fill == 1'b0)
                else $error("fill bit set outside arithmetic mode");
    end

endmodule

// File: rtl/qms_stage.sv
module qms_stage
    import qms_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             enable,
    input  stage_ctrl_t      ctrl,
    output logic [WIDTH-1:0] dout
);

    logic [DIST-1:0] left_in;
    logic [DIST-1:0] right_in;

    always_comb begin
        left_in  = ctrl.wrap ? din[WIDTH-1 -: DIST] : {DIST{ctrl.fill}};
        right_in = ctrl.wrap ? din[DIST-1:0]        : {DIST{ctrl.fill}};
        if (!enable)
            dout = din;
        else if (ctrl.go_left)
            dout = {din[WIDTH-1-DIST:0], left_in};
        else
            dout = {right_in, din[WIDTH-1:DIST]};
    end

    // R8: a rotating stage never creates or loses a 1 bit
    always_comb begin
        if (ctrl.wrap)
            assert_stage_popcount_R8: assert ($countones(dout) == $countones(din))
                else $error("stage changed the number of ones while rotating");
    end

endmodule

// File: rtl/quad_mode_shifter.sv
module quad_mode_shifter
    import qms_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] result_o
);

    stage_ctrl_t      ctrl;
    shift_mode_e      mode;
    logic [WIDTH-1:0] chain [AMT_W+1];
    logic [WIDTH-1:0] lo_mask;
    logic [WIDTH-1:0] hi_mask;

    assign mode     = shift_mode_e'(mode_i);
    assign chain[0] = data_i;

    qms_mode_decode u_decode (
        .mode_i (mode),
        .sign_i (data_i[WIDTH-1]),
        .ctrl_o (ctrl)
    );

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        qms_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << s)
        ) u_stage (
            .din    (chain[s]),
            .enable (amount_i[s]),
            .ctrl   (ctrl),
            .dout   (chain[s+1])
        );
    end

    assign result_o = chain[AMT_W];

    assign lo_mask = ~({WIDTH{1'b1}} << amount_i);
    assign hi_mask = ~({WIDTH{1'b1}} >> amount_i);

    always_comb begin
        // R6: zero distance is a pass-through
        if (amount_i == '0)
            assert_zero_amount_pass_R6: assert (result_o == data_i)
                else $error("zero amount altered operand");
        // R2 R4 R8: rotates conserve the count of ones
        if (mode == MODE_ROT_LEFT || mode == MODE_ROT_RIGHT)
            assert_rotate_popcount_R8: assert ($countones(result_o) == $countones(data_i))
                else $error("rotate changed the number of ones");
        // R3: vacated low bits are zero
        if (mode == MODE_SHIFT_LEFT)
            assert_shl_low_zero_R3: assert ((result_o & lo_mask) == '0)
                else $error("left shift left ones in vacated bits");
        // R5: vacated high bits copy the sign
        if (mode == MODE_ARITH_RIGHT)
            assert_sra_sign_fill_R5: assert ((result_o & hi_mask) == (data_i[WIDTH-1] ? hi_mask : '0))
                else $error("arithmetic shift filled with wrong bit");
    end

endmodule

// File: tb/quad_mode_shifter_test.sv
module quad_mode_shifter_test;

    logic        clk = 1'b0;
    logic [15:0] data_i;
    logic [3:0]  amount_i;
    logic [1:0]  mode_i;
    logic [15:0] result_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    quad_mode_shifter uut (
        .data_i   (data_i),
        .amount_i (amount_i),
        .mode_i   (mode_i),
        .result_o (result_o)
    );

    // vector fields: {mode, amount, operand, expected}
    localparam int NVEC = 12;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'b00, 4'd1,  16'h8001, 16'h0003},  // R2 wrap of top bit
        {2'b00, 4'd4,  16'h1234, 16'h2341},  // R2
        {2'b01, 4'd4,  16'h1234, 16'h2340},  // R3
        {2'b01, 4'd15, 16'hFFFF, 16'h8000},  // R3 largest amount
        {2'b10, 4'd1,  16'h0001, 16'h8000},  // R4 wrap of low bit
        {2'b10, 4'd8,  16'h1234, 16'h3412},  // R4
        {2'b11, 4'd15, 16'h8000, 16'hFFFF},  // R5 negative full fill
        {2'b11, 4'd15, 16'h7FFF, 16'h0000},  // R5 positive full fill
        {2'b11, 4'd4,  16'hF0F0, 16'hFF0F},  // R5
        {2'b00, 4'd0,  16'hABCD, 16'hABCD},  // R6
        {2'b11, 4'd0,  16'h8421, 16'h8421},  // R6
        {2'b10, 4'd15, 16'h00F0, 16'h01E0}   // R4 largest amount
    };

    function automatic logic [15:0] model(input logic [15:0] d, input int a, input logic [1:0] m);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            case (m)
                2'b00: r[i] = d[(i - a + 16) % 16];
                2'b01: r[i] = (i >= a) ? d[i - a] : 1'b0;
                2'b10: r[i] = d[(i + a) % 16];
                default: r[i] = (i + a < 16) ? d[i + a] : d[15];
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (result_o !== exp) begin
            fails++;
            $display("FAIL %s: mode=%b amount=%0d operand=%h actual=%h expected=%h",
                     req, mode_i, amount_i, data_i, result_o, exp);
        end
    endtask

    task automatic apply(input logic [15:0] d, input logic [3:0] a, input logic [1:0] m);
        data_i   = d;
        amount_i = a;
        mode_i   = m;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        data_i = '0; amount_i = '0; mode_i = '0;
        #2;
        check("R6 initial", 16'h0000);

        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][31:16], VEC[v][35:32], VEC[v][37:36]);
            check("R2-R6 vector", VEC[v][15:0]);
        end

        // R1 sweep of every mode and amount against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 40; n++) begin
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < 16; a++) begin
                    apply(lfsr, 4'(a), 2'(m));
                    check("R1 sweep", model(lfsr, a, 2'(m)));
                end
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        // R8 rotate keeps ones count, checked at the port
        apply(16'hF00F, 4'd7, 2'b10);
        checks++;
        if ($countones(result_o) != 8) begin
            fails++;
            $display("FAIL R8: actual=%0d expected=8", $countones(result_o));
        end

        // R7 result follows inputs mid-cycle, without a clock edge
        @(posedge clk);
        #2;
        data_i = 16'h0001; amount_i = 4'd3; mode_i = 2'b01;
        #1;
        check("R7 no-clock update", 16'h0008);
        amount_i = 4'd9;
        #1;
        check("R7 no-clock update", 16'h0200);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule